// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block records the outcome of a finished floating-point operation in the status word and decides whether the operation ends in a trap. With each completed operation it receives a five-bit vector of raised exceptions, the present status word and the present program-counter pair. It checks the raised exceptions against the trap-enable field of the status word. When any enabled exception is raised, a trap is requested. In that case the exceptions are narrowed to a single bit by a fixed priority, and the trap-type marker in the status word is set. Otherwise the exceptions are logged into the accrued field and the program counter pair moves past the instruction.

The update is computed combinationally and captured in one register stage on a clock edge where `opValid` is high. On other cycles the registered status word and PC pair hold their values. The trap request is a one-cycle pulse. Software-visible handling of the trap, detection of the exceptions and the arithmetic itself belong to other blocks.

Exception bit encoding, used in every field that holds exceptions: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. Status word layout: trap enables in bits 27:23, trap-type marker in bit 14, accrued exceptions in bits 9:5 and current exceptions in bits 4:0.

Top module: `fpx_recorder`

## Requirements
- R1: A synchronous reset clears `statusOut`, `pcOut`, `npcOut` and `trapReq` to zero.
- R2: One cycle after a strobe, `trapReq` is 1 exactly when `excFlags` AND `statusIn[27:23]` is nonzero.
- R3: On a trap, `statusOut[4:0]` holds only one bit. That bit is the highest-numbered bit of `excFlags & statusIn[27:23]`, so the priority order is invalid (4), overflow (3), underflow (2), divide-by-zero (1) and then inexact (0).
- R4: Without a trap, `statusOut[4:0]` equals `excFlags`, replacing the previous current field.
- R5: Without a trap, `statusOut[9:5]` is `statusIn[9:5] | excFlags`. On a trap it equals `statusIn[9:5]`.
- R6: On a trap, `statusOut[14]` is 1. Without a trap it equals `statusIn[14]`.
- R7: All status bits outside 14, 9:5 and 4:0 are copied from `statusIn`.
- R8: Without a trap, `pcOut` becomes `npcIn` and `npcOut` becomes `npcIn + 4`, wrapping modulo 2^PC_W.
- R9: On a trap, `pcOut` becomes `pcIn` and `npcOut` becomes `npcIn`.
- R10: On a cycle with `opValid` low, `statusOut`, `pcOut` and `npcOut` keep their values and `trapReq` is 0 on the next cycle.
- R11: An operation with `excFlags` of zero clears the current field, requests no trap and advances the PC pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opValid | input | 1 | An operation has finished; capture its result |
| excFlags | input | 5 | Raised exceptions of the finished operation |
| statusIn | input | STATUS_W | Present status word |
| pcIn | input | PC_W | Present program counter |
| npcIn | input | PC_W | Present next program counter |
| statusOut | output | STATUS_W | Registered updated status word |
| pcOut | output | PC_W | Registered program counter |
| npcOut | output | PC_W | Registered next program counter |
| trapReq | output | 1 | One-cycle trap request |

## Verification
The assertions assume that `opValid`, `excFlags`, `statusIn`, `pcIn` and `npcIn` are known and stable across each sampling edge. They also assume that the status word given with a strobe is the one the operation ran under, so the trap decision can be rebuilt from the previous cycle's inputs. The stimulus changes all inputs only on falling edges and drops the strobe between operations. It sweeps every combination of exception vector and enable mask over two background status words, including a next-PC value whose increment wraps. Idle cycles with changed inputs show that nothing moves without a strobe.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int EXC_W = 5;

  typedef logic [EXC_W-1:0] excVec_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic trap;
    logic accrue;
    logic markTrapType;
    logic advance;
  } fpxStrobe_t;
endpackage

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int TEM_LSB  = 23
) (
  input  logic                opValid,
  input  excVec_t             excFlags,
  input  logic [STATUS_W-1:0] statusIn,
  output fpxStrobe_t          strobe,
  output excVec_t             curExc
);
  excVec_t enables;
  excVec_t masked;
  excVec_t picked;
  logic    trapHit;

  assign enables = statusIn[TEM_LSB +: EXC_W];
  assign masked  = excFlags & enables;
  assign trapHit = |masked;

  // keep the highest-numbered enabled bit: invalid wins over inexact
  always_comb begin
    picked = '0;
    for (int i = 0; i < EXC_W; i++) begin
      if (masked[i]) picked = excVec_t'(1) << i;
    end
  end

  assign curExc = trapHit ? picked : excFlags;

  always_comb begin
    strobe.load         = opValid;
    strobe.trap         = opValid & trapHit;
    strobe.markTrapType = opValid & trapHit;
    strobe.accrue       = opValid & ~trapHit;
    strobe.advance      = opValid & ~trapHit;
  end
endmodule

// File: rtl/fpx_datapath.sv
module fpx_datapath
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int PC_W     = 32,
  parameter int AEXC_LSB = 5,
  parameter int CEXC_LSB = 0,
  parameter int TT_BIT   = 14,
  parameter int PC_STEP  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  fpxStrobe_t          strobe,
  input  excVec_t             curExc,
  input  excVec_t             excFlags,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic [PC_W-1:0]     pcIn,
  input  logic [PC_W-1:0]     npcIn,
  output logic [STATUS_W-1:0] statusOut,
  output logic [PC_W-1:0]     pcOut,
  output logic [PC_W-1:0]     npcOut,
  output logic                trapReq
);
  localparam logic [PC_W-1:0] STEP = PC_W'(PC_STEP);

  logic [STATUS_W-1:0] nextStatus;

  always_comb begin
    nextStatus = statusIn;
    nextStatus[CEXC_LSB +: EXC_W] = curExc;
    if (strobe.accrue)
      nextStatus[AEXC_LSB +: EXC_W] = statusIn[AEXC_LSB +: EXC_W] | excFlags;
    if (strobe.markTrapType)
      nextStatus[TT_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusOut <= '0;
      pcOut     <= '0;
      npcOut    <= '0;
      trapReq   <= 1'b0;
    end else begin
      trapReq <= strobe.trap;
      if (strobe.load) statusOut <= nextStatus;
      if (strobe.advance) begin
        pcOut  <= npcIn;
        npcOut <= npcIn + STEP;
      end else if (strobe.trap) begin
        pcOut  <= pcIn;
        npcOut <= npcIn;
      end
    end
  end
endmodule

// File: rtl/fpx_recorder.sv
module fpx_recorder
  import fpx_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int PC_W     = 32,
  parameter int TEM_LSB  = 23,
  parameter int AEXC_LSB = 5,
  parameter int CEXC_LSB = 0,
  parameter int TT_BIT   = 14,
  parameter int PC_STEP  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                opValid,
  input  logic [4:0]          excFlags,
  input  logic [STATUS_W-1:0] statusIn,
  input  logic [PC_W-1:0]     pcIn,
  input  logic [PC_W-1:0]     npcIn,
  output logic [STATUS_W-1:0] statusOut,
  output logic [PC_W-1:0]     pcOut,
  output logic [PC_W-1:0]     npcOut,
  output logic                trapReq
);
  fpxStrobe_t strobe;
  excVec_t    curExc;

  fpx_ctrl #(.STATUS_W(STATUS_W), .TEM_LSB(TEM_LSB)) u_ctrl (
    .opValid (opValid),
    .excFlags(excFlags),
    .statusIn(statusIn),
    .strobe  (strobe),
    .curExc  (curExc)
  );

  fpx_datapath #(
    .STATUS_W(STATUS_W), .PC_W(PC_W), .AEXC_LSB(AEXC_LSB),
    .CEXC_LSB(CEXC_LSB), .TT_BIT(TT_BIT), .PC_STEP(PC_STEP)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .curExc   (curExc),
    .excFlags (excFlags),
    .statusIn (statusIn),
    .pcIn     (pcIn),
    .npcIn    (npcIn),
    .statusOut(statusOut),
    .pcOut    (pcOut),
    .npcOut   (npcOut),
    .trapReq  (trapReq)
  );
endmodule

// File: rtl/fpx_recorder_chk.sv
module fpx_recorder_chk #(
  parameter int STATUS_W = 32,
  parameter int PC_W     = 32,
  parameter int TEM_LSB  = 23,
  parameter int AEXC_LSB = 5,
  parameter int CEXC_LSB = 0,
  parameter int TT_BIT   = 14
) (
  input logic                clk,
  input logic                rst,
  input logic                opValid,
  input logic [4:0]          excFlags,
  input logic [STATUS_W-1:0] statusIn,
  input logic [PC_W-1:0]     pcIn,
  input logic [PC_W-1:0]     npcIn,
  input logic [STATUS_W-1:0] statusOut,
  input logic [PC_W-1:0]     pcOut,
  input logic                trapReq
);
  logic enHit;
  assign enHit = |(excFlags & statusIn[TEM_LSB +: 5]);

  AST_TRAP_DECISION: assert property (@(posedge clk) disable iff (rst)
    opValid |=> (trapReq == $past(enHit))); // R2

  AST_TRAP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> $onehot(statusOut[CEXC_LSB +: 5])); // R3

  AST_ACCRUE_HOLD_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    (opValid && enHit) |=> (statusOut[AEXC_LSB +: 5] == $past(statusIn[AEXC_LSB +: 5]))); // R5

  AST_TRAP_TYPE_SET: assert property (@(posedge clk) disable iff (rst)
    trapReq |-> statusOut[TT_BIT]); // R6

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (opValid && !enHit) |=> (pcOut == $past(npcIn))); // R8

  AST_PC_KEEP_ON_TRAP: assert property (@(posedge clk) disable iff (rst)
    (opValid && enHit) |=> (pcOut == $past(pcIn))); // R9

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !opValid |=> ($stable(statusOut) && $stable(pcOut) && !trapReq)); // R10
endmodule

bind fpx_recorder fpx_recorder_chk #(
  .STATUS_W(STATUS_W), .PC_W(PC_W), .TEM_LSB(TEM_LSB),
  .AEXC_LSB(AEXC_LSB), .CEXC_LSB(CEXC_LSB), .TT_BIT(TT_BIT)
) u_chk (
  .clk(clk), .rst(rst), .opValid(opValid), .excFlags(excFlags),
  .statusIn(statusIn), .pcIn(pcIn), .npcIn(npcIn),
  .statusOut(statusOut), .pcOut(pcOut), .trapReq(trapReq)
);

// File: tb/fpx_recorder_bench.sv
`timescale 1ns/1ps
module fpx_recorder_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        opValid;
  logic [4:0]  excFlags;
  logic [31:0] statusIn, pcIn, npcIn;
  logic [31:0] statusOut, pcOut, npcOut;
  logic        trapReq;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fpx_recorder u_fpx_recorder (
    .clk(clk), .rst(rst), .opValid(opValid), .excFlags(excFlags),
    .statusIn(statusIn), .pcIn(pcIn), .npcIn(npcIn),
    .statusOut(statusOut), .pcOut(pcOut), .npcOut(npcOut), .trapReq(trapReq)
  );

  task automatic cmp(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] fl, input logic [31:0] st,
                       input logic [31:0] pc, input logic [31:0] npc);
    logic [4:0]  en, msk, expCur, expAcc;
    logic        expTrap;
    logic [31:0] otherMask, expPc, expNpc;
    logic [31:0] holdS, holdP, holdN;
    string       curTag, pcTag;
    en = st[27:23];
    msk = fl & en;
    expTrap = (msk != 0);
    expCur = fl;
    if (expTrap) begin
      expCur = 0;
      for (int b = 4; b >= 0; b--) if (msk[b] && expCur == 0) expCur = 5'(1 << b);
    end
    expAcc = expTrap ? st[9:5] : (st[9:5] | fl);
    expPc  = expTrap ? pc : npc;
    expNpc = expTrap ? npc : npc + 32'd4;
    otherMask = ~(32'h0000_4000 | 32'h0000_03E0 | 32'h0000_001F);
    curTag = (fl == 0) ? "R11" : (expTrap ? "R3" : "R4");
    pcTag  = expTrap ? "R9" : ((fl == 0) ? "R11" : "R8");

    @(negedge clk);
    opValid = 1'b1; excFlags = fl; statusIn = st; pcIn = pc; npcIn = npc;
    @(negedge clk);
    opValid = 1'b0;
    cmp(curTag, "current field", {27'd0, statusOut[4:0]}, {27'd0, expCur});
    cmp("R2", "trap request", {31'd0, trapReq}, {31'd0, expTrap});
    cmp("R5", "accrued field", {27'd0, statusOut[9:5]}, {27'd0, expAcc});
    cmp("R6", "trap-type bit", {31'd0, statusOut[14]}, {31'd0, (expTrap | st[14])});
    cmp("R7", "other bits", statusOut & otherMask, st & otherMask);
    cmp(pcTag, "pc", pcOut, expPc);
    cmp(pcTag, "npc", npcOut, expNpc);
    // idle cycle with disturbed inputs
    holdS = statusOut; holdP = pcOut; holdN = npcOut;
    excFlags = 5'h1F; statusIn = ~st; pcIn = ~pc; npcIn = ~npc;
    @(negedge clk);
    cmp("R10", "status hold", statusOut, holdS);
    cmp("R10", "pc hold", pcOut, holdP);
    cmp("R10", "npc hold", npcOut, holdN);
    cmp("R10", "trap idle", {31'd0, trapReq}, 32'd0);
  endtask

  initial begin
    logic [31:0] base, st, pc, npc;
    rst = 1'b1; opValid = 1'b0; excFlags = '0;
    statusIn = '0; pcIn = '0; npcIn = '0;
    repeat (3) @(negedge clk);
    // preload nonzero state so reset has something to clear
    rst = 1'b0;
    runOp(5'h03, 32'hFFFF_FFFF & ~(32'h1F << 23), 32'h40, 32'h44);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmp("R1", "status after reset", statusOut, 32'd0);
    cmp("R1", "pc after reset", pcOut, 32'd0);
    cmp("R1", "npc after reset", npcOut, 32'd0);
    cmp("R1", "trap after reset", {31'd0, trapReq}, 32'd0);
    rst = 1'b0;
    for (int pass = 0; pass < 2; pass++) begin
      base = (pass == 0) ? 32'h0000_0000 : 32'hA5A5_4A5A;
      for (int en = 0; en < 32; en++) begin
        for (int fl = 0; fl < 32; fl++) begin
          st  = (base & ~(32'h1F << 23)) | (32'(en) << 23);
          pc  = 32'h1000 + 32'(en * 256 + fl * 8);
          npc = (pass == 1 && fl == 0) ? 32'hFFFF_FFFC : pc + 32'd4;
          runOp(5'(fl), st, pc, npc);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule